// File: doc/BRIEF.md
# Triple-Sample Monotonic Counter Validator

This block reads a free-running counter whose value can glitch, and returns a value it can trust. A glitch can move the count backward or forward for a short time, so two reads compared with each other cannot show which one is good. The block therefore keeps a window of three consecutive raw samples. It accepts the window only when the samples rise strictly in capture order, and it returns the middle sample. A single wrong sample cannot be the middle of a strictly rising triple whose neighbours are correct.

A request starts a validation. The block needs at least three sample cycles before it can give a result. When a window fails, the block drops the oldest sample, takes one new sample and checks again, one cycle per retry. A parameter limits the number of checks. When that limit is reached, the block gives the middle sample of the last window and raises a timeout flag together with the result strobe. The block does not generate the counter and does not repair it. It only observes the counter and decides which sample to trust.

Top module: `triple_sample_validator`

## Requirements
- R1: While reset is held, and in the first cycle after it, `valid`, `timeout` and `result` are all zero.
- R2: An accepted request samples `cnt_in` at the accepting clock edge and at the next two edges. On a first window that passes, `valid` is high in the cycle after the third sampling edge and not before it.
- R3: A window (oldest, middle, newest) passes only when oldest < middle < newest as unsigned numbers. `result` is then the middle sample, with `timeout` low.
- R4: A window that contains two equal samples fails.
- R5: A window that a backward glitch breaks fails, and so does a window that a forward glitch breaks. A window breaks when a sample dips below the one before it or jumps above the one after it.
- R6: After a failed check, the oldest sample is dropped and one new sample is taken. Each failed check therefore delays `valid` by exactly one cycle, and the result is the middle sample of the first window that passes.
- R7: After `MAX_TRIES` checks fail, `valid` and `timeout` rise together in the cycle after the last check. `result` is then the middle sample of the last window. `timeout` is never high without `valid`.
- R8: `valid` is a one-cycle pulse, and a request raised while a validation is in progress produces no extra result.
- R9: `result` keeps its value in every cycle in which `valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Starts a validation when the block is idle |
| cnt_in | input | W (64) | Raw counter value being observed |
| valid | output | 1 | One-cycle strobe marking a new result |
| result | output | W (64) | Trusted counter value (or last middle sample on timeout) |
| timeout | output | 1 | High together with `valid` when the retry limit ended the search |

## Verification
The assertions assume that `cnt_in` holds steady around each rising edge and that reset is held across at least one edge. They also assume that `MAX_TRIES` is at least one. The bench changes `cnt_in` and `req` only on falling edges, and it drives one chosen value per cycle so that each window is known. It builds the sample sequences so that the passing window, or the absence of one, follows directly from the unsigned ordering rule. This fixes the expected cycle and value before the design runs.

// File: rtl/triple_sample_validator.sv
module triple_sample_validator #(
  parameter int W         = 64,
  parameter int MAX_TRIES = 150
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [W-1:0] cnt_in,
  output logic         valid,
  output logic [W-1:0] result,
  output logic         timeout
);

  localparam int TW = $clog2(MAX_TRIES + 1);

  logic         busy;
  logic [1:0]   fill;
  logic [W-1:0] s_old, s_mid;
  logic [TW-1:0] tries;

  wire rising   = (s_old < s_mid) && (s_mid < cnt_in);
  wire last_try = (tries == TW'(MAX_TRIES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      fill    <= 2'd0;
      s_old   <= '0;
      s_mid   <= '0;
      tries   <= '0;
      valid   <= 1'b0;
      timeout <= 1'b0;
      result  <= '0;
    end else begin
      valid   <= 1'b0;
      timeout <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy  <= 1'b1;
          fill  <= 2'd1;
          s_old <= cnt_in;
          tries <= '0;
        end
      end else if (fill == 2'd1) begin
        s_mid <= cnt_in;
        fill  <= 2'd2;
      end else if (rising || last_try) begin
        valid   <= 1'b1;
        timeout <= !rising;
        result  <= s_mid;
        busy    <= 1'b0;
        fill    <= 2'd0;
      end else begin
        s_old <= s_mid;
        s_mid <= cnt_in;
        tries <= tries + 1'b1;
      end
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R7
  timeout_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> valid);

  // R3
  result_below_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !timeout) |-> (result < $past(cnt_in)));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(result));

  // R2
  no_early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !valid);

  // R7
  tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(tries) < MAX_TRIES));

endmodule

// File: tb/sim_triple_sample_validator.sv
module sim_triple_sample_validator;
  localparam int PERIOD = 10;
  localparam int W = 64;
  localparam int MAXT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [W-1:0] cnt_in = '0;
  logic valid, timeout;
  logic [W-1:0] result;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] sv [0:15];
  int nv;

  always #(PERIOD/2) clk = ~clk;

  triple_sample_validator #(.W(W), .MAX_TRIES(MAXT)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .cnt_in(cnt_in),
    .valid(valid), .result(result), .timeout(timeout));

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drives sv[0..nv-1] one per cycle starting with a request; expects one valid at negedge exp_k.
  task automatic run_seq(input string tag, input int exp_k, input logic [W-1:0] exp_res,
                         input bit exp_to, input int req_hold);
    int seen_k = -1;
    int nvalid = 0;
    logic [W-1:0] got = '0;
    bit got_to = 1'b0;
    cnt_in = sv[0];
    req = 1'b1;
    for (int k = 1; k <= exp_k + 3; k++) begin
      @(negedge clk);
      if (valid) begin
        nvalid++;
        if (seen_k < 0) begin seen_k = k; got = result; got_to = timeout; end
      end
      if (k >= req_hold) req = 1'b0;
      cnt_in = sv[(k < nv) ? k : nv - 1];
    end
    req = 1'b0;
    chk(seen_k == exp_k, {tag, " valid cycle"}, W'(seen_k), W'(exp_k));
    chk(got == exp_res, {tag, " result"}, got, exp_res);
    chk(got_to == exp_to, {tag, " timeout"}, W'(got_to), W'(exp_to));
    chk(nvalid == 1, {tag, " single pulse R8"}, W'(nvalid), 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!valid && !timeout && result == 0, "R1 during reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!valid && !timeout && result == 0, "R1 after reset", result, 0);
  endtask

  task automatic t_clean;
    sv[0] = 100; sv[1] = 101; sv[2] = 102; nv = 3;
    run_seq("R2 R3 clean", 3, 101, 1'b0, 1);
  endtask

  task automatic t_top;
    sv[0] = 64'hFFFF_FFFF_FFFF_FFFD; sv[1] = 64'hFFFF_FFFF_FFFF_FFFE;
    sv[2] = 64'hFFFF_FFFF_FFFF_FFFF; nv = 3;
    run_seq("R3 unsigned top", 3, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1);
  endtask

  task automatic t_equal;
    sv[0] = 5; sv[1] = 5; sv[2] = 6; sv[3] = 7; nv = 4;
    run_seq("R4 equal", 4, 6, 1'b0, 1);
  endtask

  task automatic t_back;
    sv[0] = 64'h7FF; sv[1] = 64'h000; sv[2] = 64'h800; sv[3] = 64'h801; nv = 4;
    run_seq("R5 backward", 4, 64'h800, 1'b0, 1);
  endtask

  task automatic t_fwd;
    sv[0] = 64'h7FE; sv[1] = 64'hFFF; sv[2] = 64'h800; sv[3] = 64'h801; sv[4] = 64'h802; nv = 5;
    run_seq("R5 R6 forward", 5, 64'h801, 1'b0, 1);
  endtask

  task automatic t_timeout;
    for (int i = 0; i < 6; i++) sv[i] = W'(10 - i);
    nv = 6;
    run_seq("R7 timeout", 3 + MAXT - 1, 6, 1'b1, 1);
  endtask

  task automatic t_busy_req;
    sv[0] = 40; sv[1] = 50; sv[2] = 60; nv = 3;
    run_seq("R8 req while busy", 3, 50, 1'b0, 3);
  endtask

  task automatic t_hold;
    logic [W-1:0] keep;
    keep = result;
    for (int i = 0; i < 5; i++) begin
      cnt_in = W'(1000 + 7 * i);
      @(negedge clk);
      chk(!valid && result == keep, "R9 hold", result, keep);
    end
  endtask

  initial begin
    t_reset();
    t_clean();
    t_top();
    t_equal();
    t_back();
    t_fwd();
    t_timeout();
    t_busy_req();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule